// File: doc/BRIEF.md
# Four-Channel Buffered PWM Generator

The block produces up to four independent pulse-width-modulated outputs, programmed over a simple synchronous register bus. Each channel has a counter that advances once every 2^pres input clocks. A period starts at the inactive level, stays there for the programmed duty count and spends the rest of the period at the active level. A per-channel polarity bit picks which level is active.

Software starts channels through a write-one enable register and stops them through a write-one disable register. A stop takes effect only at the end of the period that is running, so the last pulse is never cut short. While a channel runs, new duty and period values go to update registers. Each value is held there and copied into the working register at the next period boundary, so the waveform has no glitch. A read-to-clear flag register records each channel's period starts, which tells software when a queued value has taken effect.

Top module: `pwmq_top`

## Requirements
- R1: After reset every output is low, the status and flag registers read 0 and every channel's mode, duty and period registers read 0.
- R2: Writing 1 to bit n of the enable register (byte offset 0x04) starts stopped channel n with its counter and prescaler at zero. Bit n of the status register (0x0C) then reads 1.
- R3: Channel n's registers sit at 0x200 + n*0x20: mode at +0x00, duty at +0x04, duty update at +0x08, period at +0x0C, period update at +0x10. A running channel is inactive for the first duty counts of each period and active for the remaining period − duty counts. The count advances once every 2^pres clocks, where pres is mode bits [3:0].
- R4: Mode bit 9 selects the polarity. When it is clear the active level is high and the inactive level is low; when it is set, both levels are inverted. A stopped channel drives its inactive level.
- R5: A value written to the duty update or period update register while the channel runs reaches the waveform only from the next period boundary on.
- R6: Writing 1 to bit n of the disable register (0x08) lets channel n finish its current period. Status bit n clears at that period end, and the output then holds the inactive level.
- R7: Flag register (0x1C) bit n is set when channel n starts a period, either on enable or at a boundary where it keeps running. A read returns all the flags and clears them, except for a period start that happens in the same cycle as the read.
- R8: While a channel is stopped, writes to its mode, duty, period and update registers take effect at once.
- R9: While a channel runs, writes to its mode, duty and period registers are ignored.
- R10: A prescaler value written above 10 is stored as 10. Mode bit 10 (update target select) is stored and reads back.
- R11: Read data appears on the cycle after the read access. The enable, disable and update offsets and every unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
Random scenarios draw a channel, period, duty, prescaler and polarity. Each scenario queues a duty update, queues a period update, tries an ignored direct write, or does nothing. The disable lands either in the first period or in the second. Because the old and new waveforms differ by cycle, this separates an update that lands at the boundary from one that lands at once or not at all. It also separates a stop at the period end from an immediate stop. Directed cases cover duty zero and duty equal to the period, prescaler saturation, read-clear of the flags, and reads of unmapped offsets.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
   localparam int BUS_W        = 32;
   localparam int OFS_ENABLE   = 'h04;
   localparam int OFS_DISABLE  = 'h08;
   localparam int OFS_STATUS   = 'h0C;
   localparam int OFS_FLAGS    = 'h1C;
   localparam int CH_BASE      = 'h200;
   localparam int CH_STRIDE    = 'h20;
   localparam int OFS_MODE     = 'h00;
   localparam int OFS_DUTY     = 'h04;
   localparam int OFS_DUTY_UPD = 'h08;
   localparam int OFS_PER      = 'h0C;
   localparam int OFS_PER_UPD  = 'h10;
   localparam int MODE_POL_BIT = 9;
   localparam int MODE_SEL_BIT = 10;
endpackage

// File: rtl/pwmq_prescaler.sv
module pwmq_prescaler #(
   parameter int PRES_W   = 4,
   parameter int MAX_PRES = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [PRES_W-1:0] pres,
   output logic              tick
);
   generate
      if (MAX_PRES == 0) begin : g_nodiv
         logic [PRES_W-1:0] unused_pres;
         assign unused_pres = pres;
         assign tick = run;
      end else begin : g_div
         localparam int DIV_W = MAX_PRES;
         logic [DIV_W-1:0] div_q;
         logic [DIV_W-1:0] mask;
         assign mask = ~({DIV_W{1'b1}} << pres);
         assign tick = run && (div_q == mask);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            div_q <= '0;
            else if (!run || tick) div_q <= '0;
            else                   div_q <= div_q + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/pwmq_chan.sv
module pwmq_chan #(
   parameter int CNT_W    = 16,
   parameter int PRES_W   = 4,
   parameter int MAX_PRES = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_req,
   input  logic              dis_req,
   input  logic              mode_we,
   input  logic              duty_we,
   input  logic              duty_upd_we,
   input  logic              per_we,
   input  logic              per_upd_we,
   input  logic [CNT_W-1:0]  wr_cnt,
   input  logic [PRES_W-1:0] wr_pres,
   input  logic              wr_pol,
   input  logic              wr_sel,
   output logic              run_o,
   output logic              start_o,
   output logic              pwm_o,
   output logic [PRES_W-1:0] pres_o,
   output logic              pol_o,
   output logic              sel_o,
   output logic [CNT_W-1:0]  duty_o,
   output logic [CNT_W-1:0]  per_o
);
   logic              run_q, stop_q, dpend_q, ppend_q, tick, last, wrap;
   logic [CNT_W-1:0]  cnt_q, duty_q, per_q, dbuf_q, pbuf_q;
   logic [CNT_W:0]    cnt_inc;
   logic [PRES_W-1:0] pres_q;
   logic              pol_q, sel_q;

   pwmq_prescaler #(.PRES_W(PRES_W), .MAX_PRES(MAX_PRES)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run_q), .pres(pres_q), .tick(tick));

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;
   assign last    = cnt_inc >= {1'b0, per_q};
   assign wrap    = run_q && tick && last;
   assign start_o = (en_req && !run_q) || (wrap && !stop_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0; stop_q <= 1'b0; cnt_q <= '0;
      end else if (en_req && !run_q) begin
         run_q <= 1'b1; stop_q <= 1'b0; cnt_q <= '0;
      end else if (run_q) begin
         if (en_req)       stop_q <= 1'b0;
         else if (dis_req) stop_q <= 1'b1;
         if (tick)         cnt_q <= last ? '0 : cnt_q + 1'b1;
         if (wrap && stop_q) begin
            run_q <= 1'b0; stop_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         duty_q <= '0; per_q <= '0; dbuf_q <= '0; pbuf_q <= '0;
         dpend_q <= 1'b0; ppend_q <= 1'b0;
         pres_q <= '0; pol_q <= 1'b0; sel_q <= 1'b0;
      end else if (!run_q) begin
         if (duty_we || duty_upd_we) duty_q <= wr_cnt;
         if (per_we || per_upd_we)   per_q  <= wr_cnt;
         if (mode_we) begin
            pres_q <= (wr_pres > PRES_W'(MAX_PRES)) ? PRES_W'(MAX_PRES) : wr_pres;
            pol_q  <= wr_pol;
            sel_q  <= wr_sel;
         end
      end else begin
         if (wrap && dpend_q) begin duty_q <= dbuf_q; dpend_q <= 1'b0; end
         if (wrap && ppend_q) begin per_q  <= pbuf_q; ppend_q <= 1'b0; end
         if (duty_upd_we) begin dbuf_q <= wr_cnt; dpend_q <= 1'b1; end
         if (per_upd_we)  begin pbuf_q <= wr_cnt; ppend_q <= 1'b1; end
      end
   end

   assign pwm_o  = pol_q ^ (run_q && (cnt_q >= duty_q));
   assign run_o  = run_q;
   assign pres_o = pres_q;
   assign pol_o  = pol_q;
   assign sel_o  = sel_q;
   assign duty_o = duty_q;
   assign per_o  = per_q;
endmodule

// File: rtl/pwmq_top.sv
module pwmq_top
   import pwmq_pkg::*;
#(
   parameter int NUM_CH     = 4,
   parameter int CNT_W      = 16,
   parameter int PRES_W     = 4,
   parameter int MAX_PRES   = 10,
   parameter int ADDR_W     = 12,
   parameter bit SHARED_UPD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   localparam int CH_SH    = $clog2(CH_STRIDE);
   localparam int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int CH_SPAN  = NUM_CH * CH_STRIDE;

   generate
      if (NUM_CH < 1 || NUM_CH > 16) begin : g_chk_ch
         $error("NUM_CH must lie in 1..16");
      end
      if (CNT_W < 2 || CNT_W >= BUS_W) begin : g_chk_cnt
         $error("CNT_W must lie in 2..31");
      end
      if (MAX_PRES >= (1 << PRES_W) || PRES_W > 4) begin : g_chk_pres
         $error("MAX_PRES must fit the 4-bit prescaler field");
      end
      if (CH_BASE + CH_SPAN > (1 << ADDR_W)) begin : g_chk_addr
         $error("ADDR_W too narrow for the channel region");
      end
   endgenerate

   logic                  acc_wr, acc_rd, ch_hit, rd_flags;
   logic [ADDR_W-1:0]     ch_rel;
   logic [CH_IDX_W-1:0]   ch_sel;
   logic [CH_SH-1:0]      ofs;
   logic [NUM_CH-1:0]     run_vec, start_vec, pol_vec, sel_vec, flag_q;
   logic [CNT_W-1:0]      duty_a [NUM_CH];
   logic [CNT_W-1:0]      per_a  [NUM_CH];
   logic [PRES_W-1:0]     pres_a [NUM_CH];
   logic [NUM_CH*PRES_W-1:0] pres_flat;
   logic [BUS_W-1:0]      rd_nxt;
   logic                  unused_wbits;

   assign unused_wbits = ^bus_wdata[BUS_W-1:CNT_W];
   assign acc_wr   = bus_en && bus_we;
   assign acc_rd   = bus_en && !bus_we;
   assign ch_rel   = bus_addr - ADDR_W'(CH_BASE);
   assign ch_hit   = (bus_addr >= ADDR_W'(CH_BASE)) && (ch_rel < ADDR_W'(CH_SPAN));
   assign ch_sel   = ch_rel[CH_SH +: CH_IDX_W];
   assign ofs      = ch_rel[CH_SH-1:0];
   assign rd_flags = acc_rd && (bus_addr == ADDR_W'(OFS_FLAGS));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      logic hit, wr_ofs_pupd;
      assign hit         = acc_wr && ch_hit && (ch_sel == CH_IDX_W'(n));
      assign wr_ofs_pupd = hit && (ofs == CH_SH'(OFS_PER_UPD));

      pwmq_chan #(.CNT_W(CNT_W), .PRES_W(PRES_W), .MAX_PRES(MAX_PRES)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .en_req     (acc_wr && (bus_addr == ADDR_W'(OFS_ENABLE))  && bus_wdata[n]),
         .dis_req    (acc_wr && (bus_addr == ADDR_W'(OFS_DISABLE)) && bus_wdata[n]),
         .mode_we    (hit && (ofs == CH_SH'(OFS_MODE))),
         .duty_we    (hit && (ofs == CH_SH'(OFS_DUTY))),
         .duty_upd_we((hit && (ofs == CH_SH'(OFS_DUTY_UPD))) ||
                      (SHARED_UPD && wr_ofs_pupd && !sel_vec[n])),
         .per_we     (hit && (ofs == CH_SH'(OFS_PER))),
         .per_upd_we (wr_ofs_pupd && (!SHARED_UPD || sel_vec[n])),
         .wr_cnt     (bus_wdata[CNT_W-1:0]),
         .wr_pres    (bus_wdata[PRES_W-1:0]),
         .wr_pol     (bus_wdata[MODE_POL_BIT]),
         .wr_sel     (bus_wdata[MODE_SEL_BIT]),
         .run_o      (run_vec[n]),
         .start_o    (start_vec[n]),
         .pwm_o      (pwm_out[n]),
         .pres_o     (pres_a[n]),
         .pol_o      (pol_vec[n]),
         .sel_o      (sel_vec[n]),
         .duty_o     (duty_a[n]),
         .per_o      (per_a[n])
      );
      assign pres_flat[n*PRES_W +: PRES_W] = pres_a[n];
   end

   always_comb begin
      rd_nxt = '0;
      if (bus_addr == ADDR_W'(OFS_STATUS))     rd_nxt = BUS_W'(run_vec);
      else if (bus_addr == ADDR_W'(OFS_FLAGS)) rd_nxt = BUS_W'(flag_q);
      else if (ch_hit) begin
         if (ofs == CH_SH'(OFS_MODE)) begin
            rd_nxt[PRES_W-1:0]   = pres_a[ch_sel];
            rd_nxt[MODE_POL_BIT] = pol_vec[ch_sel];
            rd_nxt[MODE_SEL_BIT] = sel_vec[ch_sel];
         end
         else if (ofs == CH_SH'(OFS_DUTY)) rd_nxt = BUS_W'(duty_a[ch_sel]);
         else if (ofs == CH_SH'(OFS_PER))  rd_nxt = BUS_W'(per_a[ch_sel]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
         flag_q    <= '0;
      end else begin
         if (acc_rd) bus_rdata <= rd_nxt;
         flag_q <= (rd_flags ? '0 : flag_q) | start_vec;
      end
   end
endmodule

// File: rtl/pwmq_chk.sv
module pwmq_chk
   import pwmq_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int PRES_W   = 4,
   parameter int MAX_PRES = 10,
   parameter int ADDR_W   = 12
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     bus_en,
   input logic                     bus_we,
   input logic [ADDR_W-1:0]        bus_addr,
   input logic [NUM_CH-1:0]        wbits,
   input logic [BUS_W-1:0]         bus_rdata,
   input logic [NUM_CH-1:0]        run_vec,
   input logic [NUM_CH-1:0]        start_vec,
   input logic [NUM_CH-1:0]        flag_q,
   input logic [NUM_CH*PRES_W-1:0] pres_flat
);
   p_enable_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && bus_we && bus_addr == ADDR_W'(OFS_ENABLE))
      |=> ((run_vec & $past(wbits)) == $past(wbits)));

   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr == ADDR_W'(OFS_FLAGS))
      |=> ((flag_q & ~$past(start_vec)) == '0));

   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && bus_addr >= ADDR_W'('h100) && bus_addr < ADDR_W'('h200))
      |=> (bus_rdata == '0));

   p_cmd_reads_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_en && !bus_we && (bus_addr == ADDR_W'(OFS_ENABLE) || bus_addr == ADDR_W'(OFS_DISABLE)))
      |=> (bus_rdata == '0));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_pres
      p_pres_limit_r10: assert property (@(posedge clk) disable iff (!rst_n)
         pres_flat[n*PRES_W +: PRES_W] <= PRES_W'(MAX_PRES));
   end
endmodule

bind pwmq_top pwmq_chk #(
   .NUM_CH(NUM_CH), .PRES_W(PRES_W), .MAX_PRES(MAX_PRES), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
   .wbits(bus_wdata[NUM_CH-1:0]), .bus_rdata(bus_rdata), .run_vec(run_vec),
   .start_vec(start_vec), .flag_q(flag_q), .pres_flat(pres_flat)
);

// File: tb/test_pwmq_top.sv
module test_pwmq_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   int nchk = 0, nfail = 0;
   int k = 0;
   bit chk_on = 1'b0;
   int ch = 0, p1 = 7, d1 = 0, p2 = 7, d2 = 0, pres = 0, stop_ph = 1;
   bit pol = 1'b0;
   logic [3:0] idle_pol = '0;

   pwmq_top i_pwmq_top (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out));

   always #4 clk = ~clk;

   initial begin
      #(8 * 200000);
      nfail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   function automatic int chbase(int c);
      return 'h200 + c * 'h20;
   endfunction

   function automatic bit exp_lvl(int kk);
      int t = kk >> pres;
      int c, d;
      if (t < p1) begin c = t; d = d1; end
      else if (stop_ph == 1 || t >= p1 + p2) return pol;
      else begin c = t - p1; d = d2; end
      return pol ^ (c >= d);
   endfunction

   task automatic chk(string req, int act, int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h (k=%0d)", req, act, exp, k);
      end
   endtask

   task automatic step();
      logic [3:0] e;
      if (chk_on) begin
         e = idle_pol;
         e[ch] = exp_lvl(k);
         chk("R3/R4/R5/R6 waveform", int'(pwm_out), int'(e));
      end
      @(negedge clk);
      k++;
   endtask

   task automatic bwr(int a, int d);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 12'(a); bus_wdata = 32'(d);
      step();
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic brd(int a, output int v);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = 12'(a);
      step();
      bus_en = 1'b0;
      v = int'(bus_rdata);
   endtask

   // typ: 0 none, 1 queued duty, 2 queued period, 3 ignored direct writes
   task automatic scenario(int c, int pp, int dd, int pr, bit pl, int typ, int nv,
                           bit early, bit via_upd);
      int v, b1, b2;
      chk_on = 1'b0;
      ch = c; p1 = pp; d1 = dd; pres = pr; pol = pl; p2 = pp; d2 = dd;
      bwr(chbase(c), pr | (int'(pl) << 9));
      bwr(chbase(c) + (via_upd ? 'h08 : 'h04), dd);   // R8 direct while stopped
      bwr(chbase(c) + 'h0C, pp);
      bwr('h04, 1 << c);
      k = 0; chk_on = 1'b1;
      brd('h1C, v); chk("R7 flag on enable", v, 1 << c);
      brd('h1C, v); chk("R7 flags cleared by read", v, 0);
      brd('h0C, v); chk("R2 status running", v, 1 << c);
      case (typ)
         1: begin d2 = nv; bwr(chbase(c) + 'h08, nv); step(); end
         2: begin p2 = nv; bwr(chbase(c) + 'h10, nv); step(); end
         3: begin
            bwr(chbase(c) + 'h04, nv);                       // R9 ignored
            bwr(chbase(c), (pr == 0 ? 1 : 0) | (int'(~pl) << 9));
         end
         default: begin step(); step(); end
      endcase
      b1 = p1 << pres;
      b2 = p2 << pres;
      if (early) begin
         stop_ph = 1;
         bwr('h08, 1 << c);
         while (k < b1 + 3) step();
         brd('h0C, v); chk("R6 stopped after first period", v, 0);
      end else begin
         stop_ph = 2;
         while (k < b1 + 1) step();
         brd('h1C, v); chk("R7 flag at boundary", v, 1 << c);
         bwr('h08, 1 << c);
         brd('h0C, v); chk("R6 still running until period end", v, 1 << c);
         while (k < b1 + b2 + 3) step();
         brd('h0C, v); chk("R6 stopped at period end", v, 0);
      end
      chk_on = 1'b0;
      idle_pol[c] = pl;
      brd(chbase(c) + 'h04, v); chk("R5/R9 duty register", v, d2);
      brd(chbase(c) + 'h0C, v); chk("R5 period register", v, p2);
      brd(chbase(c), v); chk("R9 mode unchanged", v, pr | (int'(pl) << 9));
   endtask

   initial begin
      int v;
      void'($urandom(32'h5EED1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 outputs low", int'(pwm_out), 0);
      brd('h0C, v); chk("R1 status zero", v, 0);
      brd('h1C, v); chk("R1 flags zero", v, 0);
      for (int c = 0; c < 4; c++) begin
         brd(chbase(c), v);         chk("R1 mode zero", v, 0);
         brd(chbase(c) + 'h04, v);  chk("R1 duty zero", v, 0);
         brd(chbase(c) + 'h0C, v);  chk("R1 period zero", v, 0);
      end
      // R10 prescaler saturation and select bit
      bwr(chbase(1), 'h60F);
      brd(chbase(1), v); chk("R10 pres clamp and bit 10", v, 'h60A);
      chk("R4 stopped inverted output", int'(pwm_out[1]), 1);
      bwr(chbase(1), 0);
      chk("R4 stopped normal output", int'(pwm_out[1]), 0);
      // R11 unmapped and write-only offsets
      bwr('h100, 'h1234);
      brd('h100, v); chk("R11 unmapped reads zero", v, 0);
      brd('h04, v);  chk("R11 enable reads zero", v, 0);
      bwr(chbase(2) + 'h08, 5);
      brd(chbase(2) + 'h08, v); chk("R11 update reads zero", v, 0);
      brd(chbase(2) + 'h04, v); chk("R8 update lands at once when stopped", v, 5);
      brd(chbase(3) + 'h14, v); chk("R11 unused channel offset", v, 0);
      // directed corner cases
      scenario(0, 7, 0, 0, 1'b0, 1, 7, 1'b0, 1'b0);
      scenario(3, 9, 9, 1, 1'b1, 2, 12, 1'b0, 1'b1);
      scenario(2, 8, 3, 2, 1'b0, 3, 1, 1'b1, 1'b0);
      scenario(1, 10, 4, 0, 1'b1, 0, 0, 1'b1, 1'b0);
      // random mix
      for (int i = 0; i < 60; i++) begin
         int rc, rp, rd, rpr, rt, rnv;
         bit rpl, re, ru;
         rc  = int'($urandom_range(3, 0));
         rp  = int'($urandom_range(14, 7));
         rd  = int'($urandom_range(rp, 0));
         rpr = int'($urandom_range(2, 0));
         rpl = 1'($urandom_range(1, 0));
         rt  = int'($urandom_range(3, 0));
         re  = 1'($urandom_range(1, 0));
         ru  = 1'($urandom_range(1, 0));
         if (rt == 1)      rnv = int'($urandom_range(rp, 0));
         else if (rt == 2) rnv = int'($urandom_range(14, 7));
         else              rnv = (rd + 3) % (rp + 1);
         scenario(rc, rp, rd, rpr, rpl, rt, rnv, re, ru);
      end
      $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule